// File: doc/BRIEF.md
# Multiplexed CPU Bus Cycle Capture

This block observes the external bus of an 8-bit processor that presents a 16-bit memory address as two bytes, one after the other, on a single 8-bit address port. Two active-high timing strobes divide every machine cycle. The first strobe marks the high address byte and the second marks the low address byte. The block rebuilds the full address from these two strobes. When the second strobe rises while either active-low memory strobe (read or write) is asserted, it also captures the byte on the data bus. The data bus pins carry that byte with its bits in reverse order.

A one-cycle address-update pulse follows every capture, and a separate data-valid pulse follows every data capture. All pin inputs pass through a synchronizer before any edge is detected. An ownership switch lets a local master take the bus. While the local master owns the bus, the block drives the strobes, the address port and, on request, the data bus. Strobe edges that the local master generates are captured exactly as processor edges are. The block also registers a set of active-low control lines and active-high flag lines toward the processor.

Top module: `bus_cycle_capture`

## Requirements
- R1: A rising edge of the upper-byte strobe writes the address-port value into bits 15..8 of `addr_q`, leaves bits 7..0 unchanged and raises `addr_upd` for exactly one cycle.
- R2: A rising edge of the lower-byte strobe writes the address-port value into bits 7..0 of `addr_q` and leaves bits 15..8 unchanged.
- R3: On a rising edge of the lower-byte strobe, the data byte is captured into `data_q` only when the read strobe or the write strobe is low, and `data_vld` then pulses for one cycle. With both strobes high, `data_q` keeps its value and `data_vld` stays low.
- R4: Pin bit i of the data bus corresponds to logical data bit 7-i. This holds both when sampling into `data_q` and when driving `pin_data_o` from `lm_wdata`.
- R5: When both address strobes rise in the same sample, the upper byte is handled first and then the lower byte. Both bytes take the same port value, and `addr_upd` produces a single one-cycle pulse.
- R6: An ownership request takes effect only when it names the other owner. On takeover, `mux_sel` goes to 1 and the strobe and address drivers are enabled. During the first owned cycle the strobes are driven to their idle levels (read and write at 1, both address strobes at 0). On release, every driver enable goes to 0 and `mux_sel` goes to 0.
- R7: `pin_data_oe` is 1 only while the local master owns the bus and `lm_wdata_en` was 1 in the previous cycle.
- R8: While the local master owns the bus, a rising edge on its own strobe (`lm_strb_a` or `lm_strb_b`) produces the same address capture and data capture as a processor edge. The result is visible two clock edges after the local input changes.
- R9: During and after reset, `ctl_o` is all ones, `flag_o` is zero, the processor owns the bus (`mux_sel` 0, all driver enables 0), and `addr_q`, `data_q`, `addr_upd` and `data_vld` are all zero.
- R10: While the local master owns the bus, edges on the processor-side strobe inputs `pin_strb_a_i` and `pin_strb_b_i` do not change `addr_q`.
- R11: `ctl_o` and `flag_o` follow `ctl_i` and `flag_i` one clock edge later. The bits of `ctl_i` are, from bit 0 up: DMA-in request, DMA-out request, interrupt, clear and wait, all active low.
- R12: A change on the processor-side pins is reflected in `addr_q` and `data_q`, and in the pulses, after the third rising clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| own_req_valid | input | 1 | Ownership request strobe |
| own_req_local | input | 1 | Requested owner: 1 local master, 0 processor |
| lm_strb_a | input | 1 | Local master upper-byte strobe |
| lm_strb_b | input | 1 | Local master lower-byte strobe |
| lm_rd_n | input | 1 | Local master read strobe, active low |
| lm_wr_n | input | 1 | Local master write strobe, active low |
| lm_addr | input | 8 | Local master address-port byte |
| lm_wdata | input | 8 | Local master write data, logical bit order |
| lm_wdata_en | input | 1 | Local master request to drive the data bus |
| pin_strb_a_i | input | 1 | Upper-byte strobe from the pin |
| pin_strb_b_i | input | 1 | Lower-byte strobe from the pin |
| pin_rd_n_i | input | 1 | Read strobe from the pin |
| pin_wr_n_i | input | 1 | Write strobe from the pin |
| pin_addr_i | input | 8 | Address port from the pins |
| pin_data_i | input | 8 | Data bus from the pins, bit-reversed |
| pin_strb_a_o | output | 1 | Driven upper-byte strobe |
| pin_strb_b_o | output | 1 | Driven lower-byte strobe |
| pin_rd_n_o | output | 1 | Driven read strobe |
| pin_wr_n_o | output | 1 | Driven write strobe |
| pin_ctl_oe | output | 1 | Output enable for the four strobes |
| pin_addr_o | output | 8 | Driven address-port byte |
| pin_addr_oe | output | 1 | Output enable for the address port |
| pin_data_o | output | 8 | Driven data bus, bit-reversed |
| pin_data_oe | output | 1 | Output enable for the data bus |
| mux_sel | output | 1 | External bus select, 1 while the local master owns the bus |
| ctl_i | input | 5 | Requested control-line levels |
| flag_i | input | 4 | Requested flag-line levels |
| ctl_o | output | 5 | Registered control lines |
| flag_o | output | 4 | Registered flag lines |
| addr_q | output | 16 | Rebuilt address |
| data_q | output | 8 | Captured data byte, logical order |
| addr_upd | output | 1 | One-cycle pulse after an address capture |
| data_vld | output | 1 | One-cycle pulse after a data capture |

## Verification
The bench alternates the upper-byte and lower-byte strobes with different port values. A design that overwrote the whole address on either strobe would lose the byte that was not updated. It raises the lower-byte strobe with both memory strobes idle, then with read low, then with write low. A design that ignored the qualifier would corrupt `data_q`, and one that did not reverse the pin bits would read back a mirrored byte. The bench also holds the local master's strobe high across a takeover. This exposes a design that does not force idle levels on the first owned cycle, and also one that re-applies a takeover on a repeated request, which would produce a spurious second capture. Finally it toggles the processor-side strobe while the local master owns the bus, to catch a source select that listens to the wrong side.

// File: rtl/bcc_pkg.sv
// Shared types for the bus cycle capture block.
// Assumes the strobe group is always handled as one unit.
package bcc_pkg;

    typedef enum logic {
        OWN_CPU   = 1'b0,
        OWN_LOCAL = 1'b1
    } owner_e;

    typedef struct packed {
        logic rd_n;
        logic wr_n;
        logic a;
        logic b;
    } strobes_t;

    localparam strobes_t STROBE_IDLE = '{rd_n: 1'b1, wr_n: 1'b1, a: 1'b0, b: 1'b0};

endpackage

// File: rtl/bcc_sync.sv
// Multi-bit synchronizer chain with a per-bit reset value.
// Assumes each bit is independent; no coherence across bits is promised.
module bcc_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= RST_VAL;
                else        chain[0] <= d;
            end
        end else begin : g_next
            // Later stages settle the sampled value.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/bcc_owner.sv
// Bus ownership state and the registered drive stage of the local master.
// A request acts only when it names the other owner. The first owned cycle
// drives idle strobes; afterwards the local master's values are registered.
// Assumes local master inputs are synchronous to clk.
module bcc_owner
    import bcc_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_local,
    input  strobes_t          lm_strb,
    input  logic [PORT_W-1:0] lm_addr,
    input  logic [PORT_W-1:0] lm_wdata,
    input  logic              lm_wdata_en,
    output owner_e            owner,
    output strobes_t          drv_strb,
    output logic [PORT_W-1:0] drv_addr,
    output logic [PORT_W-1:0] drv_data,
    output logic              ctl_oe,
    output logic              addr_oe,
    output logic              data_oe
);

    owner_e target;
    logic   do_switch;

    assign target    = req_local ? OWN_LOCAL : OWN_CPU;
    assign do_switch = req_valid && (target != owner);

    // Ownership register plus the drive registers it controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner    <= OWN_CPU;
            drv_strb <= STROBE_IDLE;
            drv_addr <= '0;
            drv_data <= '0;
            ctl_oe   <= 1'b0;
            addr_oe  <= 1'b0;
            data_oe  <= 1'b0;
        end else if (do_switch) begin
            owner    <= target;
            drv_strb <= STROBE_IDLE;
            drv_addr <= '0;
            drv_data <= '0;
            ctl_oe   <= (target == OWN_LOCAL);
            addr_oe  <= (target == OWN_LOCAL);
            data_oe  <= 1'b0;
        end else if (owner == OWN_LOCAL) begin
            drv_strb <= lm_strb;
            drv_addr <= lm_addr;
            drv_data <= lm_wdata;
            data_oe  <= lm_wdata_en;
        end else begin
            drv_strb <= STROBE_IDLE;
            data_oe  <= 1'b0;
        end
    end

endmodule

// File: rtl/bcc_capture.sv
// Edge detection on the two address strobes, address rebuild and
// qualified data capture. Upper-byte edge is applied before lower-byte
// edge when both arrive together. Assumes inputs are already synchronous.
module bcc_capture
    import bcc_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  strobes_t            src_strb,
    input  logic [PORT_W-1:0]   src_addr,
    input  logic [PORT_W-1:0]   src_data,
    output logic [2*PORT_W-1:0] addr_q,
    output logic [PORT_W-1:0]   data_q,
    output logic                addr_upd,
    output logic                data_vld
);

    logic              prev_a, prev_b;
    logic              rise_a, rise_b, mem_act;
    logic [PORT_W-1:0] addr_hi, addr_lo;

    assign rise_a  = src_strb.a & ~prev_a;
    assign rise_b  = src_strb.b & ~prev_b;
    assign mem_act = ~src_strb.rd_n | ~src_strb.wr_n;

    // Previous strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_a <= 1'b0;
            prev_b <= 1'b0;
        end else begin
            prev_a <= src_strb.a;
            prev_b <= src_strb.b;
        end
    end

    // Upper byte on strobe A, then lower byte on strobe B.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_hi <= '0;
            addr_lo <= '0;
        end else begin
            if (rise_a) addr_hi <= src_addr;
            if (rise_b) addr_lo <= src_addr;
        end
    end

    // Data byte captured only during a memory access.
    always_ff @(posedge clk) begin
        if (!rst_n)                data_q <= '0;
        else if (rise_b && mem_act) data_q <= src_data;
    end

    // One-cycle event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_upd <= 1'b0;
            data_vld <= 1'b0;
        end else begin
            addr_upd <= rise_a | rise_b;
            data_vld <= rise_b & mem_act;
        end
    end

    assign addr_q = {addr_hi, addr_lo};

endmodule

// File: rtl/bus_cycle_capture.sv
// Top of the bus cycle capture block. Synchronizes the processor-side pins,
// selects the capture source by owner, reverses the data pin order and
// registers the control and flag lines. Assumes the board routes the
// drive outputs through tri-state buffers enabled by the *_oe outputs.
module bus_cycle_capture
    import bcc_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int CTL_W       = 5,
    parameter int FLAG_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                own_req_valid,
    input  logic                own_req_local,
    input  logic                lm_strb_a,
    input  logic                lm_strb_b,
    input  logic                lm_rd_n,
    input  logic                lm_wr_n,
    input  logic [PORT_W-1:0]   lm_addr,
    input  logic [PORT_W-1:0]   lm_wdata,
    input  logic                lm_wdata_en,
    input  logic                pin_strb_a_i,
    input  logic                pin_strb_b_i,
    input  logic                pin_rd_n_i,
    input  logic                pin_wr_n_i,
    input  logic [PORT_W-1:0]   pin_addr_i,
    input  logic [PORT_W-1:0]   pin_data_i,
    output logic                pin_strb_a_o,
    output logic                pin_strb_b_o,
    output logic                pin_rd_n_o,
    output logic                pin_wr_n_o,
    output logic                pin_ctl_oe,
    output logic [PORT_W-1:0]   pin_addr_o,
    output logic                pin_addr_oe,
    output logic [PORT_W-1:0]   pin_data_o,
    output logic                pin_data_oe,
    output logic                mux_sel,
    input  logic [CTL_W-1:0]    ctl_i,
    input  logic [FLAG_W-1:0]   flag_i,
    output logic [CTL_W-1:0]    ctl_o,
    output logic [FLAG_W-1:0]   flag_o,
    output logic [2*PORT_W-1:0] addr_q,
    output logic [PORT_W-1:0]   data_q,
    output logic                addr_upd,
    output logic                data_vld
);

    localparam int SYNC_W = $bits(strobes_t) + 2 * PORT_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {STROBE_IDLE, {(2*PORT_W){1'b0}}};

    strobes_t          pin_strb_s, lm_strb, drv_strb, src_strb;
    logic [PORT_W-1:0] pin_addr_s, pin_data_s, pin_data_log;
    logic [PORT_W-1:0] drv_addr, drv_data, src_addr, src_data;
    owner_e            owner;

    assign lm_strb = '{rd_n: lm_rd_n, wr_n: lm_wr_n, a: lm_strb_a, b: lm_strb_b};

    bcc_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pin_rd_n_i, pin_wr_n_i, pin_strb_a_i, pin_strb_b_i, pin_addr_i, pin_data_i}),
        .q     ({pin_strb_s, pin_addr_s, pin_data_s})
    );

    bcc_owner #(.PORT_W(PORT_W)) u_owner (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (own_req_valid),
        .req_local   (own_req_local),
        .lm_strb     (lm_strb),
        .lm_addr     (lm_addr),
        .lm_wdata    (lm_wdata),
        .lm_wdata_en (lm_wdata_en),
        .owner       (owner),
        .drv_strb    (drv_strb),
        .drv_addr    (drv_addr),
        .drv_data    (drv_data),
        .ctl_oe      (pin_ctl_oe),
        .addr_oe     (pin_addr_oe),
        .data_oe     (pin_data_oe)
    );

    // Pin order is the mirror of logical order in both directions.
    for (genvar i = 0; i < PORT_W; i++) begin : g_rev
        assign pin_data_log[i] = pin_data_s[PORT_W-1-i];
        assign pin_data_o[i]   = drv_data[PORT_W-1-i];
    end

    // Capture source follows the current owner.
    always_comb begin
        if (owner == OWN_LOCAL) begin
            src_strb = drv_strb;
            src_addr = drv_addr;
            src_data = pin_data_oe ? drv_data : pin_data_log;
        end else begin
            src_strb = pin_strb_s;
            src_addr = pin_addr_s;
            src_data = pin_data_log;
        end
    end

    bcc_capture #(.PORT_W(PORT_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_strb (src_strb),
        .src_addr (src_addr),
        .src_data (src_data),
        .addr_q   (addr_q),
        .data_q   (data_q),
        .addr_upd (addr_upd),
        .data_vld (data_vld)
    );

    // Control lines idle high, flags idle low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_o  <= '1;
            flag_o <= '0;
        end else begin
            ctl_o  <= ctl_i;
            flag_o <= flag_i;
        end
    end

    assign mux_sel      = (owner == OWN_LOCAL);
    assign pin_strb_a_o = drv_strb.a;
    assign pin_strb_b_o = drv_strb.b;
    assign pin_rd_n_o   = drv_strb.rd_n;
    assign pin_wr_n_o   = drv_strb.wr_n;
    assign pin_addr_o   = drv_addr;

endmodule

// File: rtl/bcc_checker.sv
// Temporal checks on the ports of bus_cycle_capture, attached by bind.
module bcc_checker #(
    parameter int PORT_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mux_sel,
    input logic                pin_ctl_oe,
    input logic                pin_addr_oe,
    input logic                pin_data_oe,
    input logic                pin_rd_n_o,
    input logic                pin_wr_n_o,
    input logic                pin_strb_a_o,
    input logic                pin_strb_b_o,
    input logic [2*PORT_W-1:0] addr_q,
    input logic [PORT_W-1:0]   data_q,
    input logic                addr_upd,
    input logic                data_vld
);

    AST_ADDR_HOLDS_WITHOUT_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_upd |-> $stable(addr_q)); // R1

    AST_DATA_HOLDS_WITHOUT_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        !data_vld |-> $stable(data_q)); // R3

    AST_VLD_WITH_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        data_vld |-> addr_upd); // R2

    AST_TAKEOVER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mux_sel) |-> (pin_rd_n_o && pin_wr_n_o && !pin_strb_a_o && !pin_strb_b_o
                            && pin_ctl_oe && pin_addr_oe)); // R6

    AST_RELEASED_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
        !mux_sel |-> (!pin_ctl_oe && !pin_addr_oe && !pin_data_oe)); // R6

    AST_DATA_OE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        pin_data_oe |-> mux_sel); // R7

endmodule

bind bus_cycle_capture bcc_checker #(.PORT_W(PORT_W)) u_bcc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .mux_sel      (mux_sel),
    .pin_ctl_oe   (pin_ctl_oe),
    .pin_addr_oe  (pin_addr_oe),
    .pin_data_oe  (pin_data_oe),
    .pin_rd_n_o   (pin_rd_n_o),
    .pin_wr_n_o   (pin_wr_n_o),
    .pin_strb_a_o (pin_strb_a_o),
    .pin_strb_b_o (pin_strb_b_o),
    .addr_q       (addr_q),
    .data_q       (data_q),
    .addr_upd     (addr_upd),
    .data_vld     (data_vld)
);

// File: tb/bus_cycle_capture_bench.sv
`timescale 1ns/1ps
module bus_cycle_capture_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        own_req_valid = 1'b0, own_req_local = 1'b0;
    logic        lm_strb_a = 1'b0, lm_strb_b = 1'b0, lm_rd_n = 1'b1, lm_wr_n = 1'b1;
    logic [7:0]  lm_addr = '0, lm_wdata = '0;
    logic        lm_wdata_en = 1'b0;
    logic        pin_strb_a_i = 1'b0, pin_strb_b_i = 1'b0, pin_rd_n_i = 1'b1, pin_wr_n_i = 1'b1;
    logic [7:0]  pin_addr_i = '0, pin_data_i = '0;
    logic        pin_strb_a_o, pin_strb_b_o, pin_rd_n_o, pin_wr_n_o, pin_ctl_oe;
    logic [7:0]  pin_addr_o, pin_data_o;
    logic        pin_addr_oe, pin_data_oe, mux_sel;
    logic [4:0]  ctl_i = 5'h1F, ctl_o;
    logic [3:0]  flag_i = '0, flag_o;
    logic [15:0] addr_q;
    logic [7:0]  data_q;
    logic        addr_upd, data_vld;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bus_cycle_capture u_bus_cycle_capture (.*);

    function automatic logic [7:0] mirror8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Drive a processor cycle; sample after the third edge (R12).
    task automatic pin_cycle(input logic a, input logic b, input logic [7:0] adr,
                             input logic rd_n, input logic wr_n, input logic [7:0] dpin);
        @(negedge clk);
        pin_strb_a_i = a; pin_strb_b_i = b; pin_addr_i = adr;
        pin_rd_n_i = rd_n; pin_wr_n_i = wr_n; pin_data_i = dpin;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pin_idle();
        pin_strb_a_i = 1'b0; pin_strb_b_i = 1'b0; pin_rd_n_i = 1'b1; pin_wr_n_i = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R9", "ctl_o", ctl_o, 5'h1F);
        chk("R9", "flag_o", flag_o, 4'h0);
        chk("R9", "mux_sel", mux_sel, 1'b0);
        chk("R9", "oe", {pin_ctl_oe, pin_addr_oe, pin_data_oe}, 3'b000);
        chk("R9", "addr_q", addr_q, 16'h0000);
        chk("R9", "data_q", data_q, 8'h00);
        chk("R9", "pulses", {addr_upd, data_vld}, 2'b00);
    endtask

    task automatic t_addr_bytes();
        pin_cycle(1'b1, 1'b0, 8'h12, 1'b1, 1'b1, 8'h00);
        chk("R12", "addr_q after third edge", addr_q, 16'h1200);
        chk("R1", "addr_upd", addr_upd, 1'b1);
        @(negedge clk);
        chk("R1", "addr_upd one cycle", addr_upd, 1'b0);
        pin_idle();
        pin_cycle(1'b0, 1'b1, 8'h34, 1'b1, 1'b1, 8'hFF);
        chk("R2", "addr_q lower", addr_q, 16'h1234);
        chk("R3", "no capture when idle", {data_vld, data_q}, {1'b0, 8'h00});
        pin_idle();
        pin_cycle(1'b1, 1'b0, 8'h56, 1'b1, 1'b1, 8'h00);
        chk("R1", "lower kept", addr_q, 16'h5634);
        pin_idle();
    endtask

    task automatic t_data_capture();
        pin_cycle(1'b0, 1'b1, 8'h78, 1'b0, 1'b1, mirror8(8'hA1));
        chk("R3", "read capture", {data_vld, data_q}, {1'b1, 8'hA1});
        chk("R4", "upper kept", addr_q, 16'h5678);
        pin_idle();
        pin_cycle(1'b0, 1'b1, 8'h79, 1'b1, 1'b0, 8'h80);
        chk("R4", "write capture reversed", {data_vld, data_q}, {1'b1, 8'h01});
        pin_idle();
    endtask

    task automatic t_both();
        pin_cycle(1'b1, 1'b1, 8'h9A, 1'b1, 1'b1, 8'h00);
        chk("R5", "both bytes", addr_q, 16'h9A9A);
        chk("R5", "addr_upd", addr_upd, 1'b1);
        @(negedge clk);
        chk("R5", "single pulse", addr_upd, 1'b0);
        pin_idle();
    endtask

    task automatic t_local();
        lm_strb_a = 1'b1; lm_addr = 8'hC3;
        own_req_valid = 1'b1; own_req_local = 1'b1;
        @(posedge clk); @(negedge clk);
        own_req_valid = 1'b0;
        chk("R6", "mux_sel on takeover", mux_sel, 1'b1);
        chk("R6", "oe on takeover", {pin_ctl_oe, pin_addr_oe, pin_data_oe}, 3'b110);
        chk("R6", "idle strobes", {pin_rd_n_o, pin_wr_n_o, pin_strb_a_o, pin_strb_b_o}, 4'b1100);
        @(posedge clk); @(negedge clk);
        chk("R8", "local strobe driven", pin_strb_a_o, 1'b1);
        @(posedge clk); @(negedge clk);
        chk("R8", "local upper capture", {addr_upd, addr_q}, {1'b1, 16'hC39A});
        own_req_valid = 1'b1; own_req_local = 1'b1;
        @(posedge clk); @(negedge clk);
        own_req_valid = 1'b0;
        chk("R6", "repeat request keeps strobe", pin_strb_a_o, 1'b1);
        @(posedge clk); @(negedge clk);
        chk("R6", "no spurious capture", addr_upd, 1'b0);
        lm_strb_a = 1'b0;
        @(posedge clk); @(negedge clk);
        lm_strb_b = 1'b1; lm_wr_n = 1'b0; lm_addr = 8'h44; lm_wdata = 8'h1E; lm_wdata_en = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R7", "data oe", pin_data_oe, 1'b1);
        chk("R4", "driven data reversed", pin_data_o, 8'h78);
        chk("R8", "driven address", pin_addr_o, 8'h44);
        @(posedge clk); @(negedge clk);
        chk("R8", "local write capture", {data_vld, data_q, addr_q}, {1'b1, 8'h1E, 16'hC344});
        lm_strb_b = 1'b0; lm_wr_n = 1'b1; lm_wdata_en = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R7", "data oe off", pin_data_oe, 1'b0);
        pin_strb_a_i = 1'b1; pin_strb_b_i = 1'b1; pin_addr_i = 8'hFF;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R10", "pins ignored", addr_q, 16'hC344);
        pin_strb_a_i = 1'b0; pin_strb_b_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        own_req_valid = 1'b1; own_req_local = 1'b0;
        @(posedge clk); @(negedge clk);
        own_req_valid = 1'b0;
        chk("R6", "release", {mux_sel, pin_ctl_oe, pin_addr_oe, pin_data_oe}, 4'b0000);
        chk("R10", "no capture at release", addr_q, 16'hC344);
    endtask

    task automatic t_ctl();
        ctl_i = 5'h0A; flag_i = 4'h5;
        @(posedge clk); @(negedge clk);
        chk("R11", "ctl_o", ctl_o, 5'h0A);
        chk("R11", "flag_o", flag_o, 4'h5);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        t_addr_bytes();
        t_data_capture();
        t_both();
        t_local();
        t_ctl();
        finish_run();
    end

endmodule